// File: doc/BRIEF.md
# Fault-Hardened Register File Read Path

This block is a flip-flop register file with one write port and two independent read ports. It is built so that a single upset in the read-selection logic cannot quietly return the wrong register. Each read address is first expanded into a one-hot select vector. A separate checker tests that vector: it must have exactly one bit set, and that bit must be the one the address names. The data word is then gathered by an AND-OR network: every row is masked by its own select bit and the masked rows are ORed together. There is no binary-indexed multiplexer in the path.

Stored words are full-width codewords. The block returns the check bits unchanged beside the data bits and does not decode them. Because of this, a flip inside the AND-OR network damages at most one output bit, and a downstream error-correcting decoder can see it. Both checkers drive a single alert output. Entry 0 does not take architectural writes. It is a scratch entry that only a separate dummy write strobe can load. It reads as zero unless dummy mode is enabled.

Top module: `guarded_regfile`

## Requirements
- R1: After the active-low reset, every entry reads as all zeros on both ports and `alert_o` is low.
- R2: When `we_i` is high at a rising clock edge and `waddr_i` is in 1..NUM_REGS-1, that entry takes `wdata_i`. Both read ports return the new word from the following cycle.
- R3: An architectural write with `waddr_i` equal to 0, or with `waddr_i` at or above NUM_REGS, changes no entry. No other entry is aliased by it.
- R4: Read ports A and B select independently. In the same cycle, each returns the entry named by its own address.
- R5: While `dummy_en_i` is low, reading address 0 returns all zeros, whatever has been dummy-written.
- R6: A high `dummy_we_i` at a rising edge stores `dummy_wdata_i` into entry 0, whatever the state of `dummy_en_i`. While `dummy_en_i` is high, address 0 reads back the last word stored this way.
- R7: The full DW-bit word, with the check bits in the top bits, is returned bit for bit as written.
- R8: For any in-range read address with an intact select path, `alert_o` stays low.
- R9: A read address at or above NUM_REGS returns all zeros on that port and raises `alert_o` combinationally in the same cycle.
- R10: If a read select vector is not exactly one-hot, or is one-hot at a position other than its address, `alert_o` rises in the same cycle.

Default parameters are NUM_REGS = 32 and DW = 39. The address width is derived from NUM_REGS (5 bits by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Architectural write strobe |
| waddr_i | input | AW | Write address |
| wdata_i | input | DW | Write codeword |
| dummy_en_i | input | 1 | Makes entry 0 readable when high |
| dummy_we_i | input | 1 | Scratch write strobe for entry 0 |
| dummy_wdata_i | input | DW | Scratch word for entry 0 |
| raddr_a_i | input | AW | Read address, port A |
| rdata_a_o | output | DW | Read codeword, port A |
| raddr_b_i | input | AW | Read address, port B |
| rdata_b_o | output | DW | Read codeword, port B |
| alert_o | output | 1 | Select integrity alert, combinational |

## Verification
The bench instantiates the block with NUM_REGS = 20 and DW = 39. The address stays 5 bits wide, so addresses 20 to 31 can be driven but have no entry behind them. That makes the out-of-range write and read cases of R3 and R9 reachable at the ports, and makes it possible to check that a write to 24 does not land in entry 4 or 8. The 39-bit width puts check bits in bits 38..32, so R7 tests that those bits pass through intact. To reach R10, the bench overrides the port A select vector for a single cycle, once with a two-hot value and once with a wrong one-hot value.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

  localparam int unsigned RFG_DEF_REGS = 32;
  localparam int unsigned RFG_DEF_DW   = 39;

  // Address width that covers n entries, never below one bit.
  function automatic int unsigned rfg_addr_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rfg_sel_encoder.sv
// Binary address to one-hot select. Out-of-range addresses yield all zeros.
module rfg_sel_encoder #(
  parameter int unsigned N  = rfg_pkg::RFG_DEF_REGS,
  parameter int unsigned AW = rfg_pkg::rfg_addr_w(N)
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sel_o[i] = en_i && (addr_i == AW'(i));
  end

endmodule

// File: rtl/rfg_sel_check.sv
// Integrity test of a one-hot select against the address it came from.
// Built from a population count and a position match, not a second decoder.
module rfg_sel_check #(
  parameter int unsigned N  = rfg_pkg::RFG_DEF_REGS,
  parameter int unsigned AW = rfg_pkg::rfg_addr_w(N)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  sel_i,
  output logic          err_o
);

  logic single_bit;
  logic pos_match;

  assign single_bit = ($countones(sel_i) == 1);

  always_comb begin
    pos_match = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel_i[i] && (int'(addr_i) == i)) pos_match = 1'b1;
    end
  end

  assign err_o = !(single_bit && pos_match);

endmodule

// File: rtl/rfg_onehot_mux.sv
// AND-OR gather: each row is gated by its own select bit, then all are ORed.
module rfg_onehot_mux #(
  parameter int unsigned N  = rfg_pkg::RFG_DEF_REGS,
  parameter int unsigned DW = rfg_pkg::RFG_DEF_DW
) (
  input  logic [N-1:0][DW-1:0] rows_i,
  input  logic [N-1:0]         sel_i,
  output logic [DW-1:0]        data_o
);

  logic [N-1:0][DW-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = rows_i[i] & {DW{sel_i[i]}};
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      data_o = data_o | gated[i];
    end
  end

endmodule

// File: rtl/guarded_regfile.sv
module guarded_regfile #(
  parameter  int unsigned NUM_REGS = rfg_pkg::RFG_DEF_REGS,
  parameter  int unsigned DW       = rfg_pkg::RFG_DEF_DW,
  localparam int unsigned AW       = rfg_pkg::rfg_addr_w(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dummy_en_i,
  input  logic          dummy_we_i,
  input  logic [DW-1:0] dummy_wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o,
  output logic          alert_o
);

  localparam logic [AW:0] ADDR_LIMIT = (AW+1)'(NUM_REGS);

  logic [NUM_REGS-1:0]         wsel;
  logic [NUM_REGS-1:0][DW-1:0] rows;
  logic [NUM_REGS-1:0]         sel_a_oh;
  logic [NUM_REGS-1:0]         sel_b_oh;
  logic                        err_a;
  logic                        err_b;

  // ---------------- write decode ----------------
  rfg_sel_encoder #(.N(NUM_REGS), .AW(AW)) u_wr_enc (
    .en_i   (we_i),
    .addr_i (waddr_i),
    .sel_o  (wsel)
  );

  // ---------------- entry 0: scratch word ----------------
  logic [DW-1:0] r0_d, r0_q;

  always_comb begin
    r0_d = dummy_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_q <= '0;
    end else if (dummy_we_i) begin
      r0_q <= r0_d;
    end
  end

  assign rows[0] = dummy_en_i ? r0_q : '0;

  // ---------------- entries 1..NUM_REGS-1 ----------------
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_row
    logic [DW-1:0] row_d, row_q;

    always_comb begin
      row_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (wsel[i]) begin
        row_q <= row_d;
      end
    end

    assign rows[i] = row_q;
  end

  // ---------------- read port A ----------------
  rfg_sel_encoder #(.N(NUM_REGS), .AW(AW)) u_enc_a (
    .en_i   (1'b1),
    .addr_i (raddr_a_i),
    .sel_o  (sel_a_oh)
  );

  rfg_sel_check #(.N(NUM_REGS), .AW(AW)) u_chk_a (
    .addr_i (raddr_a_i),
    .sel_i  (sel_a_oh),
    .err_o  (err_a)
  );

  rfg_onehot_mux #(.N(NUM_REGS), .DW(DW)) u_mux_a (
    .rows_i (rows),
    .sel_i  (sel_a_oh),
    .data_o (rdata_a_o)
  );

  // ---------------- read port B ----------------
  rfg_sel_encoder #(.N(NUM_REGS), .AW(AW)) u_enc_b (
    .en_i   (1'b1),
    .addr_i (raddr_b_i),
    .sel_o  (sel_b_oh)
  );

  rfg_sel_check #(.N(NUM_REGS), .AW(AW)) u_chk_b (
    .addr_i (raddr_b_i),
    .sel_i  (sel_b_oh),
    .err_o  (err_b)
  );

  rfg_onehot_mux #(.N(NUM_REGS), .DW(DW)) u_mux_b (
    .rows_i (rows),
    .sel_i  (sel_b_oh),
    .data_o (rdata_b_o)
  );

  // ---------------- alert ----------------
  assign alert_o = err_a | err_b;

  // ---------------- assertions ----------------
  // R2
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (waddr_i != '0) && ({1'b0, waddr_i} < ADDR_LIMIT))
    |=> (raddr_a_i != $past(waddr_i)) || alert_o || (rdata_a_o == $past(wdata_i)));

  // R3
  wr_r0_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel[0] && !dummy_we_i) |=> $stable(r0_q));

  // R5
  r0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dummy_en_i && (raddr_b_i == '0) && !alert_o) |-> (rdata_b_o == '0));

  // R9
  oob_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, raddr_a_i} >= ADDR_LIMIT) |-> (alert_o && (rdata_a_o == '0)));

  // R10
  sel_integrity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$onehot(sel_a_oh) || !$onehot(sel_b_oh)) |-> alert_o);

endmodule

// File: tb/guarded_regfile_bench.sv
module guarded_regfile_bench;

  localparam int unsigned N  = 20;
  localparam int unsigned DW = 39;
  localparam int unsigned AW = 5;

  typedef struct {
    int            port;
    logic [DW-1:0] exp_data;
    bit            chk_data;
    bit            exp_alert;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic          den;
  logic          dwe;
  logic [DW-1:0] dwdata;
  logic [AW-1:0] ra, rb;
  logic [DW-1:0] da, db;
  logic          alert;

  int checks = 0;
  int fails  = 0;
  item_t q[$];

  logic [DW-1:0] mdl [N];
  logic [DW-1:0] mdl_r0;
  bit            mdl_den;

  always #10 clk = ~clk;

  guarded_regfile #(.NUM_REGS(N), .DW(DW)) u_guarded_regfile (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .we_i          (we),
    .waddr_i       (waddr),
    .wdata_i       (wdata),
    .dummy_en_i    (den),
    .dummy_we_i    (dwe),
    .dummy_wdata_i (dwdata),
    .raddr_a_i     (ra),
    .rdata_a_o     (da),
    .raddr_b_i     (rb),
    .rdata_b_o     (db),
    .alert_o       (alert)
  );

  function automatic logic [DW-1:0] expect_word(input int a);
    if (a >= int'(N)) return '0;
    if (a == 0) return mdl_den ? mdl_r0 : '0;
    return mdl[a];
  endfunction

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a >= 1 && a < int'(N)) mdl[a] = d;
  endtask

  task automatic do_dummy(input logic [DW-1:0] d);
    @(negedge clk);
    dwe = 1'b1; dwdata = d;
    @(negedge clk);
    dwe = 1'b0;
    mdl_r0 = d;
  endtask

  task automatic set_den(input bit v);
    @(negedge clk);
    den = v;
    mdl_den = v;
  endtask

  task automatic do_read(input int a, input int b, input string tag);
    bit ea;
    @(negedge clk);
    ra = AW'(a); rb = AW'(b);
    ea = (a >= int'(N)) || (b >= int'(N));
    q.push_back('{0, expect_word(a), 1'b1, ea, tag});
    q.push_back('{1, expect_word(b), 1'b1, ea, tag});
  endtask

  task automatic do_fault_a(input int a, input logic [N-1:0] bad, input string tag);
    @(negedge clk);
    ra = AW'(a); rb = 5'd1;
    force u_guarded_regfile.sel_a_oh = bad;
    q.push_back('{0, '0, 1'b0, 1'b1, tag});
    #10;
    release u_guarded_regfile.sel_a_oh;
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [DW-1:0] got;
        it  = q.pop_front();
        got = (it.port == 0) ? da : db;
        if (it.chk_data) begin
          checks++;
          if (got !== it.exp_data) begin
            fails++;
            $display("FAIL %s port%0d data got=%h exp=%h", it.tag, it.port, got, it.exp_data);
          end
        end
        checks++;
        if (alert !== it.exp_alert) begin
          fails++;
          $display("FAIL %s port%0d alert got=%b exp=%b", it.tag, it.port, alert, it.exp_alert);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; waddr = '0; wdata = '0;
    den = 1'b1; mdl_den = 1'b1; dwe = 1'b0; dwdata = '0;
    ra = '0; rb = '0; mdl_r0 = '0;
    for (int i = 0; i < int'(N); i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all entries zero after reset, no alert
    for (int i = 0; i < int'(N); i += 2) do_read(i, i + 1, "R1");

    // R2 / R7: writes with check bits set, visible on both ports
    do_write(3, 39'h7F_DEAD_BEEF);
    do_write(5, 39'h55_0000_0001);
    do_write(15, 39'h2A_FFFF_FFFF);
    do_write(19, 39'h01_8000_0000);
    do_read(3, 3, "R2");
    do_read(19, 5, "R7");
    // R4: independent selection
    do_read(5, 15, "R4");
    do_read(15, 19, "R4");
    // R8: in-range reads raise no alert
    do_read(1, 18, "R8");

    // R3: writes to 0 and to unbacked addresses are dropped, no aliasing
    do_write(4, 39'h11_2222_3333);
    do_write(8, 39'h44_5555_6666);
    do_write(0, 39'h7F_FFFF_FFFF);
    do_write(24, 39'h33_CAFE_F00D);
    do_write(31, 39'h66_ABCD_0123);
    do_read(4, 8, "R3");
    do_read(0, 11, "R3");

    // R5: entry 0 reads zero with dummy mode off, even after a dummy write
    set_den(1'b0);
    do_dummy(39'h5A_A5A5_A5A5);
    do_read(0, 0, "R5");
    // R6: dummy write taken while disabled is visible once enabled
    set_den(1'b1);
    do_read(0, 3, "R6");
    do_dummy(39'h12_3456_789A);
    do_read(0, 0, "R6");

    // R9: unbacked read addresses return zero and alert
    do_read(20, 3, "R9");
    do_read(5, 31, "R9");
    do_read(7, 7, "R8");

    // R10: faulted port-A select (two-hot, then wrong one-hot)
    do_fault_a(5, 20'h08020, "R10");
    do_fault_a(5, 20'h08000, "R10");
    do_read(5, 15, "R10");

    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    #20;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule